// File: doc/BRIEF.md
# Multichannel Audio Receive Holding Registers

This block sits between an audio deserializer and a processor bus. It stores the most recent received sample for each channel of up to four stereo pairs (eight channels) in a holding register. Every holding register carries two flags: a ready flag, set when a word lands, and an overrun flag, set when a word lands before the previous one was read. Both flags are cleared as side effects of bus reads. Reading a holding register clears its ready flag. Reading the shared status register clears all overrun flags.

The serializer side presents each finished word with a strobe. In stereo mode it also gives a pair number and a left/right select. In time-division mode it gives a slot number instead. Even slots land in the left register and odd slots land in the right register of pair slot/2. The processor side issues single-cycle reads. A level interrupt is raised whenever any flag is set whose bit is also set in an enable mask.

Top module: `audio_rx_hold`

## Requirements
- R1: After reset every ready and overrun flag is clear, `rd_data` is zero and `irq` is low.
- R2: In stereo mode (`tdm_mode`=0) a word strobe stores `word_data` in channel index `word_pair*2 + word_right` and sets that channel's ready flag. `word_slot` has no effect in this mode.
- R3: In time-division mode (`tdm_mode`=1) a word for slot s goes to pair s/2, to the left register when s is even and the right register when s is odd. The channel index is therefore s, and `word_pair`/`word_right` have no effect.
- R4: A read at address i (0..7) returns the held sample of channel i on `rd_data` in the next cycle. The sample is right-justified and the upper bits are zero. The read clears that channel's ready flag.
- R5: A word arriving for a channel whose ready flag is set, with no read of that channel in the same cycle, overwrites the held sample, keeps ready set and sets the overrun flag.
- R6: When a word arrives in the same cycle as a read of that channel, the read returns the old sample. The new sample is stored, ready stays set and no overrun is flagged.
- R7: A read at address 8 returns the status word: ready flags in bits 7:0 and overrun flags in bits 15:8, with bit position equal to the channel index and bits 31:16 zero. The read clears every overrun flag and leaves the ready flags alone.
- R8: An overrun event in the same cycle as a status read leaves that channel's overrun flag set.
- R9: `irq` is high exactly when the bitwise AND of the status bits 15:0 and `irq_en` is non-zero.
- R10: A read at addresses 9..15 returns zero and changes no flag.
- R11: A cycle with no read returns zero on `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tdm_mode | input | 1 | 1: route words by slot number; 0: by pair and side |
| word_vld | input | 1 | A completed word is presented this cycle |
| word_pair | input | 2 | Stereo pair number (stereo mode) |
| word_right | input | 1 | 1 selects the right channel of the pair (stereo mode) |
| word_slot | input | 3 | Time-division slot number |
| word_data | input | 24 | Received sample, right-justified |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | 4 | Read address: 0..7 holding registers, 8 status |
| rd_data | output | 32 | Read result, valid the cycle after `rd_en` |
| irq_en | input | 16 | Interrupt enable mask over the status bits |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at collisions. It drives a word into a channel while the same register is being read, which a design that let the clear win would answer by dropping a ready flag or reporting a false overrun. It drives an overrun in the same cycle as a status read, where a plain clear loses the event. It checks that an overrun overwrites the sample, not discards it, that time-division slots honour parity rather than the stereo pair inputs, and that unmapped reads do not clear anything. A long random phase compares every output on every cycle against a behavioural model.

// File: rtl/arh_pkg.sv
package arh_pkg;

  // channel index from a stereo pair number and side
  function automatic int unsigned pair_side_idx(int unsigned pair, bit right);
    return pair * 2 + (right ? 1 : 0);
  endfunction

  // pair that a time-division slot lands in
  function automatic int unsigned slot_pair(int unsigned slot);
    return slot / 2;
  endfunction

  // odd slots go to the right register
  function automatic bit slot_is_right(int unsigned slot);
    return (slot % 2) == 1;
  endfunction

endpackage

// File: rtl/arh_slot_map.sv
module arh_slot_map #(
  parameter int CHANS  = 8,
  parameter int IDX_W  = 3,
  parameter int PAIR_W = 2
) (
  input  logic              vld,
  input  logic              tdm_mode,
  input  logic [PAIR_W-1:0] pair,
  input  logic              right,
  input  logic [IDX_W-1:0]  slot,
  output logic [CHANS-1:0]  hit
);
  import arh_pkg::*;

  logic [IDX_W-1:0] idx;

  always_comb begin
    int unsigned p;
    bit          r;
    if (tdm_mode) begin
      p = slot_pair(int'(slot));
      r = slot_is_right(int'(slot));
    end else begin
      p = int'(pair);
      r = right;
    end
    idx = IDX_W'(pair_side_idx(p, r));
    hit = '0;
    if (vld) hit[idx] = 1'b1;
  end

endmodule

// File: rtl/arh_hold_chan.sv
module arh_hold_chan #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [SW-1:0] wr_data,
  input  logic          rd,
  input  logic          stat_rd,
  output logic [SW-1:0] data,
  output logic          ready,
  output logic          ovf,
  output logic          ovf_evt
);

  // new word while the old one is still unread and not being read now
  assign ovf_evt = wr && ready && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      ready <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (wr) data <= wr_data;
      if (wr)      ready <= 1'b1;
      else if (rd) ready <= 1'b0;
      if (ovf_evt)      ovf <= 1'b1;
      else if (stat_rd) ovf <= 1'b0;
    end
  end

  // R4: a read with no competing word clears ready
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !wr |=> !ready);
  // R6: an arriving word always leaves ready set and its data stored
  a_r6_word_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ready && data == $past(wr_data));
  // R5: an unread channel hit again records overrun
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf && ready);
  // R7: a status read with no new event clears overrun
  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ovf_evt |=> !ovf);
  // R8: event and status read together keep the flag
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && ovf_evt |=> ovf);

endmodule

// File: rtl/arh_reg_read.sv
module arh_reg_read #(
  parameter int CHANS = 8,
  parameter int SW    = 24,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [SW-1:0]    hold   [CHANS],
  input  logic [CHANS-1:0] ready,
  input  logic [CHANS-1:0] ovf,
  output logic [CHANS-1:0] rd_hit,
  output logic             stat_rd,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] sel;

  for (genvar g = 0; g < CHANS; g++) begin : g_dec
    assign rd_hit[g] = rd_en && (rd_addr == AW'(g));
  end
  assign stat_rd = rd_en && (rd_addr == AW'(CHANS));

  always_comb begin
    sel = '0;
    if (stat_rd) sel = DW'({ovf, ready});
    for (int i = 0; i < CHANS; i++) begin
      if (rd_hit[i]) sel = DW'(hold[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sel;
  end

  // R10: addresses above the status register read as zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr > AW'(CHANS) |=> rd_data == '0);
  // R11: idle cycles return zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);

endmodule

// File: rtl/audio_rx_hold.sv
module audio_rx_hold #(
  parameter int NUM_PAIRS = 4,
  parameter int SAMPLE_W  = 24,
  localparam int CHANS    = 2 * NUM_PAIRS,
  localparam int IDX_W    = $clog2(CHANS),
  localparam int PAIR_W   = $clog2(NUM_PAIRS),
  localparam int AW       = IDX_W + 1,
  localparam int STAT_W   = 2 * CHANS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tdm_mode,
  input  logic                word_vld,
  input  logic [PAIR_W-1:0]   word_pair,
  input  logic                word_right,
  input  logic [IDX_W-1:0]    word_slot,
  input  logic [SAMPLE_W-1:0] word_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [31:0]         rd_data,
  input  logic [STAT_W-1:0]   irq_en,
  output logic                irq
);

  logic [CHANS-1:0]    wr_hit, rd_hit, rdy, ovf, ovf_evt;
  logic                stat_rd;
  logic [SAMPLE_W-1:0] hold [CHANS];

  arh_slot_map #(.CHANS(CHANS), .IDX_W(IDX_W), .PAIR_W(PAIR_W)) u_map (
    .vld(word_vld), .tdm_mode(tdm_mode), .pair(word_pair),
    .right(word_right), .slot(word_slot), .hit(wr_hit)
  );

  for (genvar g = 0; g < CHANS; g++) begin : g_chan
    arh_hold_chan #(.SW(SAMPLE_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr(wr_hit[g]), .wr_data(word_data),
      .rd(rd_hit[g]), .stat_rd(stat_rd), .data(hold[g]),
      .ready(rdy[g]), .ovf(ovf[g]), .ovf_evt(ovf_evt[g])
    );
  end

  arh_reg_read #(.CHANS(CHANS), .SW(SAMPLE_W), .AW(AW), .DW(32)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .hold(hold), .ready(rdy), .ovf(ovf), .rd_hit(rd_hit),
    .stat_rd(stat_rd), .rd_data(rd_data)
  );

  assign irq = |({ovf, rdy} & irq_en);

  // R2: stereo word marks the channel chosen by pair and side
  a_r2_stereo_route: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && !tdm_mode |=> rdy[{$past(word_pair), $past(word_right)}]);
  // R3: time-division word marks the channel equal to its slot
  a_r3_slot_route: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && tdm_mode |=> rdy[$past(word_slot)]);
  // R9: a cleared mask silences the interrupt
  a_r9_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == '0 |-> !irq);
  // R5: at most one channel written per cycle
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: tb/audio_rx_hold_tb.sv
module audio_rx_hold_tb_top;
  localparam int CH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tdm_mode = 1'b0, word_vld = 1'b0, word_right = 1'b0, rd_en = 1'b0;
  logic [1:0]  word_pair = '0;
  logic [2:0]  word_slot = '0;
  logic [23:0] word_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] irq_en = '0;
  logic [31:0] rd_data;
  logic        irq;

  int errors = 0, checks = 0, cycles = 0;

  // behavioural model
  int unsigned m_data [CH];
  bit          m_rdy  [CH];
  bit          m_ovf  [CH];
  logic [31:0] m_rd = '0;
  string       m_tag = "R1";

  always #2 clk = ~clk;

  audio_rx_hold dut_i (
    .clk(clk), .rst_n(rst_n), .tdm_mode(tdm_mode), .word_vld(word_vld),
    .word_pair(word_pair), .word_right(word_right), .word_slot(word_slot),
    .word_data(word_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_en(irq_en), .irq(irq)
  );

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    for (int i = 0; i < CH; i++) begin
      s[i]      = m_rdy[i];
      s[i + CH] = m_ovf[i];
    end
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) begin
        m_data[i] = 0; m_rdy[i] = 0; m_ovf[i] = 0;
      end
      m_rd = '0; m_tag = "R1";
    end else begin
      int w;
      bit st;
      w = -1;
      if (word_vld) w = tdm_mode ? int'(word_slot) : int'(word_pair) * 2 + int'(word_right);
      st = rd_en && rd_addr == 4'd8;
      m_rd = '0; m_tag = "R11";
      if (rd_en) begin
        if (rd_addr < 4'd8) begin m_rd = m_data[rd_addr]; m_tag = "R4"; end
        else if (st) begin m_rd = m_status(); m_tag = "R7"; end
        else m_tag = "R10";
      end
      for (int i = 0; i < CH; i++) begin
        bit wr, rd, ev;
        wr = (i == w);
        rd = rd_en && rd_addr == 4'(i);
        ev = wr && m_rdy[i] && !rd;
        if (wr) begin m_data[i] = word_data; m_rdy[i] = 1; end
        else if (rd) m_rdy[i] = 0;
        if (ev) m_ovf[i] = 1;
        else if (st) m_ovf[i] = 0;
      end
    end
  end

  // every-cycle comparison, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(m_tag, rd_data, m_rd);
      check("R9", {31'd0, irq}, {31'd0, |(m_status()[15:0] & irq_en)});
    end
  end

  task automatic cyc(bit wv, bit tdm, int pair, bit right, int slot, int data,
                     bit re, int addr, output logic [31:0] rv);
    @(negedge clk); #1;
    word_vld = wv; tdm_mode = tdm; word_pair = 2'(pair); word_right = right;
    word_slot = 3'(slot); word_data = 24'(data); rd_en = re; rd_addr = 4'(addr);
    @(posedge clk); #1;
    word_vld = 0; rd_en = 0;
    rv = rd_data;
  endtask

  task automatic rd(int addr, output logic [31:0] rv);
    cyc(0, 0, 0, 0, 0, 0, 1, addr, rv);
  endtask

  task automatic wst(int pair, bit right, int data);
    logic [31:0] d;
    cyc(1, 0, pair, right, 0, data, 0, 0, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1", rd_data, 0);
    check("R1", {31'd0, irq}, 0);
    rd(8, v); check("R1", v, 0);

    // R2 stereo routing: pair 1 right -> index 3; slot ignored
    cyc(1, 0, 1, 1, 6, 'hABCDEF, 0, 0, v);
    rd(8, v); check("R2", v, 32'h0000_0008);
    // R4 read returns zero-extended sample and clears ready
    rd(3, v); check("R4", v, 32'h00AB_CDEF);
    rd(8, v); check("R4", v, 0);

    // R3 slot 6 -> pair 3 left; pair/right inputs conflict and are ignored
    cyc(1, 1, 0, 1, 6, 'h123456, 0, 0, v);
    rd(8, v); check("R3", v, 32'h0000_0040);
    rd(6, v); check("R3", v, 32'h0012_3456);
    cyc(1, 1, 3, 0, 1, 'h000777, 0, 0, v);
    rd(1, v); check("R3", v, 32'h0000_0777);

    // R5 overrun overwrites, keeps ready
    wst(0, 0, 'h111);
    wst(0, 0, 'h222);
    rd(8, v); check("R5", v, 32'h0000_0101);
    // R7 status read cleared overrun, ready kept
    rd(8, v); check("R7", v, 32'h0000_0001);
    rd(0, v); check("R5", v, 32'h0000_0222);

    // R6 word and read of same register together
    wst(1, 0, 'h0AA);
    cyc(1, 0, 1, 0, 0, 'h0BB, 1, 2, v); check("R6", v, 32'h0000_00AA);
    rd(8, v); check("R6", v, 32'h0000_0004);
    rd(2, v); check("R6", v, 32'h0000_00BB);

    // R8 overrun coinciding with status read
    wst(2, 1, 'h1);
    cyc(1, 0, 2, 1, 0, 'h2, 1, 8, v); check("R8", v, 32'h0000_0020);
    rd(8, v); check("R8", v, 32'h0000_2020);

    // R9 interrupt mask
    @(negedge clk); irq_en = 16'h0000;
    @(posedge clk); #1; check("R9", {31'd0, irq}, 0);
    @(negedge clk); irq_en = 16'h0020;
    @(posedge clk); #1; check("R9", {31'd0, irq}, 1);
    @(negedge clk); irq_en = 16'h2000;
    @(posedge clk); #1; check("R9", {31'd0, irq}, 0);

    // R10 unmapped read returns zero and clears nothing
    wst(3, 1, 'h55);
    wst(3, 1, 'h66);
    rd(12, v); check("R10", v, 0);
    rd(8, v); check("R10", v, 32'h0000_8080 | 32'h0000_0020);
    rd(11, v); check("R11", v, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, v); check("R11", v, 0);

    // random phase, compared each cycle by the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      irq_en    = 16'($urandom);
      word_vld  = ($urandom % 3) != 0;
      tdm_mode  = $urandom % 2;
      word_pair = 2'($urandom);
      word_right = $urandom % 2;
      word_slot = 3'($urandom);
      word_data = 24'($urandom);
      rd_en     = ($urandom % 2) == 1;
      rd_addr   = 4'($urandom);
    end
    @(negedge clk); #1; word_vld = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule